// File: doc/BRIEF.md
# Double-Buffered Window Configuration Bank

This block keeps the scan-out configuration of three overlay windows in two copies. Software writes a shadow copy through a simple word-addressed register port. Scan-out logic only sees the active copy. The active copy changes only on a frame-boundary pulse, and only after software has asked for a transfer with a self-clearing update bit.

Each window has its own hold bit in a shared control register. While a window's hold bit is set, a transfer at a boundary skips that window and leaves its active values alone. Software can therefore rewrite a window's full configuration over many cycles without a partial set ever reaching the display. Register reads always return the shadow copy. For every window that takes a transfer, the block raises a one-cycle copy strobe.

Top module: `wsb_bank`

## Requirements
- R1: After reset, every active field, every copy strobe, every shadow register, the hold bits and the pending update read or drive zero.
- R2: Writes to window registers land in the shadow copy and read back at once. Unimplemented bits read 0. Active outputs do not change on a write. Window n occupies word addresses 0x10+8n to 0x15+8n, at offsets 0 control, 1 start, 2 end, 3 base address, 4 end address, 5 line size. Offsets 6 and 7 read 0.
- R3: Writing 1 to bit 0 of the update register at address 0x01 sets a pending request, and that bit reads 1. The request clears itself on the next frame-boundary pulse.
- R4: On a frame boundary with a request pending, every window whose hold bit is clear copies all of its shadow fields to its active outputs. That window's commit strobe is high for exactly the one cycle in which the new values first appear.
- R5: The hold bit for window n is bit 10+n of the shadow-control register at address 0x00. A window that is held at the boundary keeps its previous active values and raises no strobe. After its hold bit is cleared, a later request and boundary copy it.
- R6: A frame boundary with no request pending changes no active value and raises no strobe.
- R7: In the control word, bit 0 is the window enable, bits 5:2 are the pixel-format code and bits 11:10 are the burst length (0 for 16 words, 1 for 8, 2 for 4). Each field reaches the matching active output.
- R8: The start and end words hold X in bits 23:12 and Y in bits 11:0. The end point is inclusive, and both points are carried unchanged.
- R9: The line-size word holds the line offset in bits 27:14 and the page width in bytes in bits 13:0.
- R10: An update write in the same cycle as a boundary pulse is kept for the following boundary. Writing 0 to the update bit does not cancel a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data from the shadow copy, combinational on addr_i |
| frame_i | input | 1 | Frame-boundary pulse |
| act_en_o | output | 3 | Active enable per window |
| act_fmt_o | output | 12 | Active format code, 4 bits per window |
| act_burst_o | output | 6 | Active burst length, 2 bits per window |
| act_sx_o | output | 36 | Active start X, 12 bits per window |
| act_sy_o | output | 36 | Active start Y, 12 bits per window |
| act_ex_o | output | 36 | Active end X, 12 bits per window |
| act_ey_o | output | 36 | Active end Y, 12 bits per window |
| act_base_o | output | 96 | Active base address, 32 bits per window |
| act_end_o | output | 96 | Active end address, 32 bits per window |
| act_offs_o | output | 42 | Active line offset, 14 bits per window |
| act_width_o | output | 42 | Active page width, 14 bits per window |
| commit_o | output | 3 | One-cycle copy strobe per window |

## Verification
The bench holds one window while it rewrites it and asks for a transfer. A bank that ignored the hold bit would show a strobe for that window with a half-new configuration, and the scoreboard would report it as an unexpected item. Boundaries with no request pending catch a bank that copies on every frame. An update written in the same cycle as a boundary catches a bank that drops the request, and a later write of 0 catches a bank that lets software cancel it. Writing all-ones patterns exposes field slices that are shifted or swapped between the X and Y halves, or between the offset and width halves.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  localparam int NWIN    = 3;
  localparam int FMT_W   = 4;
  localparam int BURST_W = 2;
  localparam int CRD_W   = 12;
  localparam int ADR_W   = 32;
  localparam int LINE_W  = 14;
  localparam int PROT_LSB = 10;

  localparam logic [7:0] CTL_ADDR = 8'h00;
  localparam logic [7:0] UPD_ADDR = 8'h01;
  localparam int         WIN_BLK  = 2;  // window n at word 8*(WIN_BLK+n)

  typedef struct packed {
    logic               en;
    logic [FMT_W-1:0]   fmt;
    logic [BURST_W-1:0] burst;
    logic [CRD_W-1:0]   sx;
    logic [CRD_W-1:0]   sy;
    logic [CRD_W-1:0]   ex;
    logic [CRD_W-1:0]   ey;
    logic [ADR_W-1:0]   base;
    logic [ADR_W-1:0]   lim;
    logic [LINE_W-1:0]  offs;
    logic [LINE_W-1:0]  width;
  } win_cfg_t;

  function automatic logic [31:0] win_rd(win_cfg_t c, logic [2:0] off);
    case (off)
      3'd0:    return {20'd0, c.burst, 4'd0, c.fmt, 1'b0, c.en};
      3'd1:    return {8'd0, c.sx, c.sy};
      3'd2:    return {8'd0, c.ex, c.ey};
      3'd3:    return c.base;
      3'd4:    return c.lim;
      3'd5:    return {4'd0, c.offs, c.width};
      default: return 32'd0;
    endcase
  endfunction
endpackage

// File: rtl/wsb_regfile.sv
module wsb_regfile
  import wsb_pkg::*;
#(
  parameter int NW = NWIN
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic        frame_i,
  output logic [31:0] rdata_o,
  output win_cfg_t    shadow_o [NW],
  output logic [NW-1:0] prot_o,
  output logic        pend_o
);
  logic [NW-1:0] prot_q;
  logic          pend_q;
  logic          upd_wr;
  win_cfg_t      shadow_q [NW];
  logic          unused_bits;

  assign unused_bits = ^wdata_i;
  assign upd_wr = wr_en_i && (addr_i == UPD_ADDR) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == CTL_ADDR) prot_q <= wdata_i[PROT_LSB +: NW];
      if (upd_wr)       pend_q <= 1'b1;
      else if (frame_i) pend_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NW; i++) begin : g_sh
    logic hit;
    assign hit = wr_en_i && (addr_i[7:3] == 5'(WIN_BLK + i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) shadow_q[i] <= '0;
      else if (hit) begin
        case (addr_i[2:0])
          3'd0: begin
            shadow_q[i].en    <= wdata_i[0];
            shadow_q[i].fmt   <= wdata_i[5:2];
            shadow_q[i].burst <= wdata_i[11:10];
          end
          3'd1: begin
            shadow_q[i].sx <= wdata_i[23:12];
            shadow_q[i].sy <= wdata_i[11:0];
          end
          3'd2: begin
            shadow_q[i].ex <= wdata_i[23:12];
            shadow_q[i].ey <= wdata_i[11:0];
          end
          3'd3: shadow_q[i].base <= wdata_i;
          3'd4: shadow_q[i].lim  <= wdata_i;
          3'd5: begin
            shadow_q[i].offs  <= wdata_i[27:14];
            shadow_q[i].width <= wdata_i[13:0];
          end
          default: ;
        endcase
      end
    end
    assign shadow_o[i] = shadow_q[i];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTL_ADDR) rdata_o[PROT_LSB +: NW] = prot_q;
    else if (addr_i == UPD_ADDR) rdata_o[0] = pend_q;
    for (int i = 0; i < NW; i++)
      if (addr_i[7:3] == 5'(WIN_BLK + i)) rdata_o = win_rd(shadow_q[i], addr_i[2:0]);
  end

  assign prot_o = prot_q;
  assign pend_o = pend_q;

  // R3
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i && !upd_wr |=> !pend_q);
  // R10
  pend_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_wr |=> pend_q);
endmodule

// File: rtl/wsb_win_active.sv
module wsb_win_active
  import wsb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  logic     prot_i,
  input  win_cfg_t shadow_i,
  output win_cfg_t act_o,
  output logic     commit_o
);
  logic take;
  assign take = load_i && !prot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o    <= '0;
      commit_o <= 1'b0;
    end else begin
      commit_o <= take;
      if (take) act_o <= shadow_i;
    end
  end

  // R4
  copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !prot_i |=> commit_o && act_o == $past(shadow_i));
  // R5
  prot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && prot_i |=> $stable(act_o) && !commit_o);
  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_o) && !commit_o);
endmodule

// File: rtl/wsb_bank.sv
module wsb_bank
  import wsb_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [7:0]              addr_i,
  input  logic [31:0]             wdata_i,
  output logic [31:0]             rdata_o,
  input  logic                    frame_i,
  output logic [NWIN-1:0]         act_en_o,
  output logic [NWIN*FMT_W-1:0]   act_fmt_o,
  output logic [NWIN*BURST_W-1:0] act_burst_o,
  output logic [NWIN*CRD_W-1:0]   act_sx_o,
  output logic [NWIN*CRD_W-1:0]   act_sy_o,
  output logic [NWIN*CRD_W-1:0]   act_ex_o,
  output logic [NWIN*CRD_W-1:0]   act_ey_o,
  output logic [NWIN*ADR_W-1:0]   act_base_o,
  output logic [NWIN*ADR_W-1:0]   act_end_o,
  output logic [NWIN*LINE_W-1:0]  act_offs_o,
  output logic [NWIN*LINE_W-1:0]  act_width_o,
  output logic [NWIN-1:0]         commit_o
);
  win_cfg_t        shadow [NWIN];
  win_cfg_t        act    [NWIN];
  logic [NWIN-1:0] prot;
  logic            pend;
  logic            load;

  wsb_regfile #(.NW(NWIN)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .frame_i,
    .rdata_o, .shadow_o(shadow), .prot_o(prot), .pend_o(pend)
  );

  assign load = frame_i && pend;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    wsb_win_active u_act (
      .clk_i, .rst_ni, .load_i(load), .prot_i(prot[i]),
      .shadow_i(shadow[i]), .act_o(act[i]), .commit_o(commit_o[i])
    );
    assign act_en_o[i]                       = act[i].en;
    assign act_fmt_o[i*FMT_W +: FMT_W]       = act[i].fmt;
    assign act_burst_o[i*BURST_W +: BURST_W] = act[i].burst;
    assign act_sx_o[i*CRD_W +: CRD_W]        = act[i].sx;
    assign act_sy_o[i*CRD_W +: CRD_W]        = act[i].sy;
    assign act_ex_o[i*CRD_W +: CRD_W]        = act[i].ex;
    assign act_ey_o[i*CRD_W +: CRD_W]        = act[i].ey;
    assign act_base_o[i*ADR_W +: ADR_W]      = act[i].base;
    assign act_end_o[i*ADR_W +: ADR_W]       = act[i].lim;
    assign act_offs_o[i*LINE_W +: LINE_W]    = act[i].offs;
    assign act_width_o[i*LINE_W +: LINE_W]   = act[i].width;
  end

  // R4
  commit_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |commit_o |-> $past(pend) && $past(frame_i));
endmodule

// File: tb/sim_wsb_bank.sv
`timescale 1ns/1ps
module sim_wsb_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        frame = 1'b0;
  logic [31:0] rdata;
  logic [2:0]  act_en, commit;
  logic [11:0] act_fmt;
  logic [5:0]  act_burst;
  logic [35:0] act_sx, act_sy, act_ex, act_ey;
  logic [95:0] act_base, act_end;
  logic [41:0] act_offs, act_width;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [1:0]       win;
    logic [5:0][31:0] w;
  } exp_t;

  logic [5:0][31:0] sh [3];
  exp_t q [$];

  always #2.5 clk = ~clk;

  wsb_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .frame_i(frame), .act_en_o(act_en), .act_fmt_o(act_fmt),
    .act_burst_o(act_burst), .act_sx_o(act_sx), .act_sy_o(act_sy), .act_ex_o(act_ex),
    .act_ey_o(act_ey), .act_base_o(act_base), .act_end_o(act_end),
    .act_offs_o(act_offs), .act_width_o(act_width), .commit_o(commit)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_mask(int off);
    case (off)
      0: return 32'h0000_0C3D;
      1, 2: return 32'h00FF_FFFF;
      3, 4: return 32'hFFFF_FFFF;
      5: return 32'h0FFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_win(int n, int off, logic [31:0] d);
    wr(8'(8'h10 + 8 * n + off), d);
    sh[n][off] = d;
  endtask

  task automatic rd_check(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 check(req, 64'(rdata), 64'(exp));
  endtask

  // driver: pushes an expected item per unheld window when a request is pending
  task automatic boundary(logic [2:0] held, bit pending);
    if (pending)
      for (int n = 0; n < 3; n++)
        if (!held[n]) q.push_back('{win: 2'(n), w: sh[n]});
    @(negedge clk);
    frame = 1'b1;
    @(negedge clk);
    frame = 1'b0;
    @(negedge clk);
    check("R4 R6 queue drained", 64'(q.size()), 64'd0);
  endtask

  task automatic act_check(string req, int n, logic [5:0][31:0] w);
    check({req, " ctrl"}, 64'({act_en[n], act_fmt[n*4 +: 4], act_burst[n*2 +: 2]}),
          64'({w[0][0], w[0][5:2], w[0][11:10]}));
    check({req, " coords"}, 64'({act_sx[n*12 +: 12], act_sy[n*12 +: 12], act_ex[n*12 +: 12], act_ey[n*12 +: 12]}),
          64'({w[1][23:12], w[1][11:0], w[2][23:12], w[2][11:0]}));
    check({req, " addrs"}, {act_base[n*32 +: 32], act_end[n*32 +: 32]}, {w[3], w[4]});
    check({req, " line"}, 64'({act_offs[n*14 +: 14], act_width[n*14 +: 14]}),
          64'({w[5][27:14], w[5][13:0]}));
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      for (int n = 0; n < 3; n++) begin
        if (commit[n]) begin
          if (q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R5 R6: unexpected strobe on window %0d, actual 1 expected 0", n);
          end else begin
            exp_t e;
            e = q.pop_front();
            check("R4 window index", 64'(n), 64'(e.win));
            act_check("R4 R7 R8 R9 copy", n, e.w);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0][31:0] old1;
    for (int n = 0; n < 3; n++) sh[n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1 strobes", 64'(commit), 64'd0);
    for (int n = 0; n < 3; n++) act_check("R1 active", n, sh[n]);
    rd_check("R1 hold bits", 8'h00, 32'd0);
    rd_check("R1 pending", 8'h01, 32'd0);
    rd_check("R1 shadow", 8'h13, 32'd0);

    // R2 R7 R8 R9: shadow write, readback masks, active untouched
    for (int off = 0; off < 8; off++) begin
      wr(8'(8'h10 + off), 32'hFFFF_FFFF);
      rd_check("R2 readback mask", 8'(8'h10 + off), rd_mask(off));
    end
    wr_win(0, 0, 32'h0000_0415);   // en=1 fmt=5 burst=1
    wr_win(0, 1, 32'h0010_2030);
    wr_win(0, 2, 32'h004F_F1DF);
    wr_win(0, 3, 32'h8000_1000);
    wr_win(0, 4, 32'h8005_3000);
    wr_win(0, 5, 32'h0000_C140);
    rd_check("R8 start word", 8'h11, 32'h0010_2030);
    rd_check("R9 line word", 8'h15, 32'h0000_C140);
    check("R2 active unchanged", 64'(act_base[31:0]), 64'd0);

    // R6 boundary with no request
    boundary(3'b000, 1'b0);
    check("R6 active still zero", 64'(act_en), 64'd0);

    // R3 request then boundary: all windows copy
    wr(8'h01, 32'h1);
    rd_check("R3 pending set", 8'h01, 32'h1);
    boundary(3'b000, 1'b1);
    rd_check("R3 pending cleared", 8'h01, 32'h0);
    act_check("R7 R8 R9 window0 active", 0, sh[0]);

    // R5 hold window 1 while rewriting it
    wr(8'h00, 32'h1 << 11);
    rd_check("R5 hold readback", 8'h00, 32'h0000_0800);
    wr_win(1, 0, 32'h0000_083D);   // en=1 fmt=15 burst=2
    wr_win(1, 1, 32'h00AB_C123);
    wr_win(1, 2, 32'h00FF_FFFF);
    wr_win(1, 3, 32'h1234_5678);
    wr_win(1, 4, 32'h9ABC_DEF0);
    wr_win(1, 5, 32'h0FFF_C000);
    wr_win(0, 0, 32'h0000_0001);
    old1 = '0;
    wr(8'h01, 32'h1);
    boundary(3'b010, 1'b1);
    act_check("R5 held window unchanged", 1, old1);
    act_check("R5 unheld window copied", 0, sh[0]);
    wr(8'h00, 32'h0);
    wr(8'h01, 32'h1);
    boundary(3'b000, 1'b1);
    act_check("R5 released window copied", 1, sh[1]);

    // R10 update write coinciding with a boundary
    wr_win(2, 3, 32'hCAFE_0000);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'h01; wdata = 32'h1; frame = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; frame = 1'b0;
    check("R10 no copy without prior request", 64'(act_base[64 +: 32]), 64'd0);
    rd_check("R10 request kept", 8'h01, 32'h1);
    // R10 writing 0 does not cancel
    wr(8'h01, 32'h0);
    rd_check("R10 zero write ignored", 8'h01, 32'h1);
    boundary(3'b000, 1'b1);
    check("R10 window2 base copied", 64'(act_base[64 +: 32]), 64'h0000_0000_CAFE_0000);
    rd_check("R3 pending cleared again", 8'h01, 32'h0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule